// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial port through which a host programs eight 12-bit configuration registers. Commands arrive one bit at a time on a serial input. A bit is taken only on master-clock edges where the word-rate strobe is high, and each such edge is called a slot. A command frame opens with a low start bit, which is also the slot where the read/write select is captured. Fifteen more bits follow, holding twelve data bits and then a three-bit register number. The frame takes effect only if the slot after those fifteen bits carries a high stop level.

All eight registers are driven out in parallel for the gain, configuration and DAC-code logic around the block. The highest register is a status register. An event input sets its bits, and they stay set until a zero is written to them. A read frame returns a 16-bit image on the serial output. The image holds a zero, then the selected register's twelve bits, then its three-bit number. The selected register is the one named by the most recent frame that committed. The read frame commits too, so reading the same register twice returns its current contents on the second read.

Top module: `sctl_port`

## Requirements
- R1: A write frame commits when the slot after its 15 payload bits carries a 1. A write frame has start bit 0 and `rd_sel` low in the start slot. Its payload is sent MSB first as bits 14:3 data and bits 2:0 address. On commit, register `addr` takes the data in `reg_bank[addr*12 +: 12]`, visible from the cycle after the stop slot.
- R2: Values on `cmd_in` and `rd_sel` in cycles where `word_stb` is low have no effect.
- R3: A frame whose stop slot carries 0 is dropped. No register changes and no write pulse occurs. The next 0 seen in a later slot starts a new frame.
- R4: When `rd_sel` is high in the start slot, the frame is a read. Its commit changes no register and produces no write pulse.
- R5: In a read frame, `ser_out` presents the image {0, data[11:0], addr[2:0]} MSB first. The register shown is the one named by the most recent committed frame, which is register 0 after reset. Image bit 15-k is valid from the k-th slot edge after the start slot's edge until the next slot edge, for k = 0 to 15. At all other times `ser_out` is 1.
- R6: While `rst_n` is low, every register is 0, `ser_out` is 1 and `wr_pulse` is 0.
- R7: While `suspend` is high, frames are ignored, a frame in progress is abandoned, and no register changes except through `evt_in`.
- R8: In register 7, a high `evt_in[i]` sets bit i one cycle later. A committed write to register 7 clears exactly the bits written 0 and leaves the bits written 1 unchanged. A set in the same cycle as a clear takes priority.
- R9: A committed write raises `wr_pulse` for exactly one cycle, the cycle after the stop slot, with `wr_addr` equal to the written address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | Word-rate strobe qualifying sample slots |
| cmd_in | input | 1 | Serial command input, idle high |
| rd_sel | input | 1 | Read (1) / write (0) select, taken in the start slot |
| suspend | input | 1 | Blocks register access while high |
| evt_in | input | 12 | Event inputs that set status register bits |
| ser_out | output | 1 | Serial readback output, idle high |
| reg_bank | output | 96 | All eight registers, register i at bits i*12 +: 12 |
| wr_pulse | output | 1 | One-cycle pulse on a committed write |
| wr_addr | output | 3 | Address of the committed write |

## Verification
Register contents and `wr_pulse` change on the stop slot's clock edge. The bench reads them only after the full frame task returns, and it counts pulses with a monitor that samples every rising edge. Each readback bit appears on the slot edge that shifts it. The bench latches `ser_out` on the falling edge just after each slot edge, which places the image MSB first at the start slot. A status event shows in register 7 one edge after it is driven, and the bench reads it on the next falling edge. Between slots the serial input carries the opposite of the intended bit, so any sampling outside a slot corrupts the written value.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned SCTL_DW = 12;
  localparam int unsigned SCTL_AW = 3;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_BODY = 2'd1,
    FR_STOP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/sctl_framer.sv
module sctl_framer
  import sctl_pkg::*;
#(
  parameter int unsigned DW = SCTL_DW,
  parameter int unsigned AW = SCTL_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_stb,
  input  logic          cmd_in,
  input  logic          rd_sel,
  input  logic          suspend,
  output logic          start_ev,
  output logic          shift_ev,
  output logic          stop_ev,
  output logic          commit,
  output logic          cmd_rd,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  localparam int unsigned BODY = DW + AW;
  localparam int unsigned CW   = $clog2(BODY + 1);

  fr_state_e       state;
  logic [CW-1:0]   cnt;
  logic [BODY-1:0] sh;
  logic            rd_q;

  assign start_ev = !suspend && word_stb && (state == FR_IDLE) && !cmd_in;
  assign shift_ev = !suspend && word_stb && (state == FR_BODY);
  assign stop_ev  = !suspend && word_stb && (state == FR_STOP);
  assign commit   = stop_ev && cmd_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      cnt   <= '0;
      sh    <= '0;
      rd_q  <= 1'b0;
    end else if (suspend) begin
      state <= FR_IDLE;
    end else if (start_ev) begin
      state <= FR_BODY;
      cnt   <= '0;
      rd_q  <= rd_sel;
    end else if (shift_ev) begin
      sh  <= {sh[BODY-2:0], cmd_in};
      cnt <= cnt + 1'b1;
      if (cnt == CW'(BODY - 1)) state <= FR_STOP;
    end else if (stop_ev) begin
      state <= FR_IDLE;
    end
  end

  assign cmd_rd   = rd_q;
  assign cmd_addr = sh[AW-1:0];
  assign cmd_data = sh[BODY-1:AW];
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
#(
  parameter int unsigned DW = SCTL_DW,
  parameter int unsigned AW = SCTL_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [DW-1:0]           evt_in,
  output logic [(1<<AW)*DW-1:0]   regs_flat
);
  localparam int unsigned NREG     = 1 << AW;
  localparam int unsigned STAT_IDX = NREG - 1;

  function automatic logic [DW-1:0] sticky_next(
    input logic [DW-1:0] cur, input logic clr_en,
    input logic [DW-1:0] keep_mask, input logic [DW-1:0] set_bits);
    logic [DW-1:0] kept;
    kept = clr_en ? (cur & keep_mask) : cur;
    return kept | set_bits;
  endfunction

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic [DW-1:0] r;
    logic          hit;
    assign hit = wr_en && (wr_addr == AW'(gi));
    if (gi == STAT_IDX) begin : g_status
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= sticky_next(r, hit, wr_data, evt_in);
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   r <= '0;
        else if (hit) r <= wr_data;
      end
    end
    assign regs_flat[gi*DW +: DW] = r;
  end
endmodule

// File: rtl/sctl_readback.sv
module sctl_readback #(
  parameter int unsigned FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          suspend,
  input  logic          load,
  input  logic [FW-1:0] image,
  input  logic          shift,
  input  logic          stop,
  output logic          ser_out,
  output logic          active
);
  logic [FW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      active <= 1'b0;
    end else if (suspend) begin
      active <= 1'b0;
    end else if (load) begin
      sh     <= image;
      active <= 1'b1;
    end else if (active && shift) begin
      sh <= {sh[FW-2:0], 1'b1};
    end else if (stop) begin
      active <= 1'b0;
    end
  end

  assign ser_out = active ? sh[FW-1] : 1'b1;
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int unsigned DW = SCTL_DW,
  parameter int unsigned AW = SCTL_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_stb,
  input  logic                  cmd_in,
  input  logic                  rd_sel,
  input  logic                  suspend,
  input  logic [DW-1:0]         evt_in,
  output logic                  ser_out,
  output logic [(1<<AW)*DW-1:0] reg_bank,
  output logic                  wr_pulse,
  output logic [AW-1:0]         wr_addr
);
  localparam int unsigned FW = 1 + DW + AW;

  function automatic logic [FW-1:0] frame_image(input logic [DW-1:0] d,
                                                input logic [AW-1:0] a);
    return {1'b0, d, a};
  endfunction

  logic          start_ev, shift_ev, stop_ev, commit_ev, cmd_rd, tx_active;
  logic [AW-1:0] cmd_addr, rd_ptr;
  logic [DW-1:0] cmd_data;
  logic          write_ev;

  sctl_framer #(.DW(DW), .AW(AW)) u_framer (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .cmd_in(cmd_in),
    .rd_sel(rd_sel), .suspend(suspend), .start_ev(start_ev),
    .shift_ev(shift_ev), .stop_ev(stop_ev), .commit(commit_ev),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  assign write_ev = commit_ev && !cmd_rd;

  sctl_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(write_ev), .wr_addr(cmd_addr),
    .wr_data(cmd_data), .evt_in(evt_in), .regs_flat(reg_bank)
  );

  sctl_readback #(.FW(FW)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .suspend(suspend),
    .load(start_ev && rd_sel),
    .image(frame_image(reg_bank[rd_ptr*DW +: DW], rd_ptr)),
    .shift(shift_ev), .stop(stop_ev), .ser_out(ser_out), .active(tx_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
    end else begin
      wr_pulse <= write_ev;
      if (commit_ev) rd_ptr <= cmd_addr;
      if (write_ev)  wr_addr <= cmd_addr;
    end
  end
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int unsigned DW = 12,
  parameter int unsigned AW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  word_stb,
  input logic                  suspend,
  input logic [DW-1:0]         evt_in,
  input logic [(1<<AW)*DW-1:0] reg_bank,
  input logic                  ser_out,
  input logic                  wr_pulse
);
  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned SLO  = (NREG - 1) * DW;

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  p_suspend_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> !wr_pulse);

  p_slot_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(reg_bank[SLO-1:0]));

  p_ser_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_stb && !suspend) |=> $stable(ser_out));

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((reg_bank[SLO +: DW] & $past(evt_in)) == $past(evt_in)));
endmodule

bind sctl_port sctl_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .suspend(suspend),
  .evt_in(evt_in), .reg_bank(reg_bank), .ser_out(ser_out), .wr_pulse(wr_pulse)
);

// File: tb/sctl_port_bench.sv
module sctl_port_bench;
  localparam int DW = 12;
  localparam int AW = 3;
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {12'hA5C, 3'd0}, {12'hFFF, 3'd1}, {12'h000, 3'd2}, {12'h800, 3'd3},
    {12'h001, 3'd4}, {12'h3C7, 3'd5}, {12'h5AA, 3'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0, word_stb = 1'b0, cmd_in = 1'b1;
  logic rd_sel = 1'b0, suspend = 1'b0;
  logic [DW-1:0] evt_in = '0;
  logic ser_out, wr_pulse;
  logic [AW-1:0] wr_addr;
  logic [8*DW-1:0] reg_bank;

  int tests = 0, fails = 0, pulses = 0;
  logic [AW-1:0] last_wa = '0;
  logic [15:0] rb;
  logic [DW-1:0] model [8];
  bit done = 0;

  always #2.5 clk = ~clk;

  sctl_port u_sctl_port (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .cmd_in(cmd_in),
    .rd_sel(rd_sel), .suspend(suspend), .evt_in(evt_in), .ser_out(ser_out),
    .reg_bank(reg_bank), .wr_pulse(wr_pulse), .wr_addr(wr_addr)
  );

  always @(posedge clk) if (wr_pulse) begin pulses++; last_wa = wr_addr; end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One slot: strobe high for one cycle, three idle cycles carrying junk.
  task automatic slot(input logic b, input logic rs, output logic so);
    @(negedge clk); word_stb = 1'b1; cmd_in = b; rd_sel = rs;
    @(negedge clk); word_stb = 1'b0; cmd_in = ~b; rd_sel = ~rs; so = ser_out;
    @(negedge clk);
    @(negedge clk); cmd_in = 1'b1;
  endtask

  task automatic frame(input logic rs, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic stop_bit);
    logic [14:0] body;
    logic so;
    body = {d, a};
    slot(1'b0, rs, so); rb[15] = so;
    for (int i = 14; i >= 0; i--) begin slot(body[i], 1'b0, so); rb[i] = so; end
    slot(stop_bit, 1'b0, so);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R6 regs at reset", reg_bank[31:0], 0);
    check("R6 ser_out at reset", ser_out, 1);
    check("R6 wr_pulse at reset", wr_pulse, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table-driven writes; junk between slots also exercises R2.
    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      frame(1'b0, VEC[v][2:0], VEC[v][14:3], 1'b1);
      model[VEC[v][2:0]] = VEC[v][14:3];
      check("R1 R2 register value", reg_bank[VEC[v][2:0]*DW +: DW], VEC[v][14:3]);
      check("R9 one pulse", pulses - p0, 1);
      check("R9 pulse address", last_wa, VEC[v][2:0]);
    end

    // Read twice: second read returns register 3.
    p0 = pulses;
    frame(1'b1, 3'd3, 12'h000, 1'b1);
    check("R5 first read image (ptr=6)", rb, {1'b0, model[6], 3'd6});
    frame(1'b1, 3'd3, 12'h000, 1'b1);
    check("R5 readback image reg3", rb, {1'b0, model[3], 3'd3});
    check("R4 read leaves reg3", reg_bank[3*DW +: DW], model[3]);
    check("R4 read makes no pulse", pulses - p0, 0);
    check("R5 idle ser_out", ser_out, 1);

    // Missing stop bit, then a good frame.
    p0 = pulses;
    frame(1'b0, 3'd5, 12'h111, 1'b0);
    check("R3 dropped frame reg5", reg_bank[5*DW +: DW], model[5]);
    check("R3 dropped frame pulses", pulses - p0, 0);
    frame(1'b0, 3'd5, 12'h222, 1'b1);
    model[5] = 12'h222;
    check("R3 next frame accepted", reg_bank[5*DW +: DW], 12'h222);

    // Suspended frame ignored.
    p0 = pulses;
    suspend = 1'b1;
    frame(1'b0, 3'd2, 12'hBEE, 1'b1);
    check("R7 suspended frame reg2", reg_bank[2*DW +: DW], model[2]);
    check("R7 suspended pulses", pulses - p0, 0);
    suspend = 1'b0;
    @(negedge clk);

    // Status register: sticky set, write-zero clear.
    evt_in = 12'h0A5;
    @(negedge clk); evt_in = '0;
    check("R8 status set", reg_bank[7*DW +: DW], 12'h0A5);
    @(negedge clk);
    check("R8 status sticky", reg_bank[7*DW +: DW], 12'h0A5);
    frame(1'b0, 3'd7, 12'hFF0, 1'b1);
    check("R8 write-zero clears low nibble", reg_bank[7*DW +: DW], 12'h0A0);
    frame(1'b0, 3'd7, 12'hFFF, 1'b1);
    check("R8 write-one keeps", reg_bank[7*DW +: DW], 12'h0A0);

    // Asynchronous reset mid-run.
    #1 rst_n = 1'b0;
    #1;
    check("R6 async reset reg0", reg_bank[0 +: DW], 0);
    check("R6 async reset reg7", reg_bank[7*DW +: DW], 0);
    check("R6 async reset ser_out", ser_out, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule